// File: doc/BRIEF.md
# SD/MMC Host Interrupt Event Status and Mask Unit

This unit keeps the interrupt event status word of an SD/MMC host controller and drives the controller's single interrupt line. Hardware events set individual status bits. Some events arrive as one-cycle pulses. Others are found by watching state signals for a falling edge. Two more come from comparing the data buffer fill level against the programmed block length. Software reads the word and acknowledges events by writing 1 to the bits it has handled.

A summary error bit in the word shows whether any error event is pending, and software cannot write it. Each status position has a matching enable bit. The interrupt line is a registered OR of every status bit that is both set and enabled. Software uses the status word, at address 0, and the enable word, at address 1, through a plain synchronous write port and a combinational read port.

Status bit layout, least significant first: 0 command done, 1 transfer done, 2 halted at block gap, 3 read block available, 4 write block space, 5 DMA event, 6 card interrupt, 7 boot acknowledge, 15 error summary, and 16+i for error input `err_evt[i]` with i from 0 to 8. All other positions are unused.

Top module: `irq_evt_unit`

## Requirements
- R1: After reset the status word, the enable word and `irq` are all 0.
- R2: Status bit 0 is set in the cycle after `cmd_busy` goes from 1 to 0. A rise of `cmd_busy`, or holding it at a steady level, sets nothing.
- R3: When `rd_mode` is 1, status bit 1 is set in the cycle after `rd_active` falls. A fall of `dat_active` in this mode has no effect.
- R4: When `rd_mode` is 0, status bit 1 is set in the cycle after `dat_active` falls. A fall of `rd_active` in this mode has no effect.
- R5: A pulse on `gap_halt` sets both status bit 1 and status bit 2.
- R6: When `rd_mode` is 1 and `blk_len` is nonzero, status bit 3 is set once each time `buf_fill` goes from below `blk_len` to at least `blk_len`. Staying above the threshold does not set it again.
- R7: When `rd_mode` is 0 and `blk_len` is nonzero, status bit 4 is set once each time the free space (BUF_DEPTH minus `buf_fill`) goes from below `blk_len` to at least `blk_len`.
- R8: Pulses on `dma_evt`, `card_evt`, `boot_evt` and `err_evt[i]` set status bits 5, 6, 7 and 16+i.
- R9: Status bit 15 reads 1 exactly when any of bits 24..16 is 1. Writing to bit 15 has no effect.
- R10: A write to address 0 clears every status bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R11: If a hardware set and a software clear reach the same status bit in the same cycle, the bit ends up set.
- R12: `irq` goes to 1 one cycle after any status bit is 1 while its enable bit at address 1 is 1, and it stays 0 while no set bit is enabled.
- R13: Unused status positions (8..14 and 25..31) always read 0. All enable bits can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_busy | input | 1 | Command line reserved; its falling edge means the command is finished |
| rd_active | input | 1 | Read transfer in progress |
| dat_active | input | 1 | DAT lines in use |
| rd_mode | input | 1 | 1 = read direction, 0 = write direction |
| gap_halt | input | 1 | Pulse: transfer stopped at a block gap |
| dma_evt | input | 1 | Pulse: DMA event |
| card_evt | input | 1 | Pulse: card interrupt |
| boot_evt | input | 1 | Pulse: boot acknowledge received |
| err_evt | input | 9 | Pulses: error events, bit i maps to status bit 16+i |
| buf_fill | input | 10 | Words currently held in the data buffer |
| blk_len | input | 10 | Programmed block length in words |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status word, 1 = enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Combined registered interrupt |

## Verification
The edge-driven bits are tested with rising edges, steady levels and falling edges of each state signal, in both directions. This separates detection of a true 1-to-0 transition from plain level sensing, and shows that the correct active signal is chosen by direction. The threshold bits are driven across the block length, held above it, and moved in the direction that does not apply, so a one-shot crossing event can be told apart from a level compare. The error pulses are cleared one bit at a time, which shows whether the summary bit follows the whole error field or only a single bit. Clear-versus-set collisions and the enable mask are tested against the interrupt timing, which exposes a missing output register or a wrong clear priority.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

   // status word layout (positions other than the error field are local choice)
   localparam int P_CMD   = 0;
   localparam int P_XFER  = 1;
   localparam int P_GAP   = 2;
   localparam int P_RDRDY = 3;
   localparam int P_WRRDY = 4;
   localparam int P_DMA   = 5;
   localparam int P_CARD  = 6;
   localparam int P_BOOT  = 7;
   localparam int N_PLAIN = 8;

   localparam logic ADDR_STAT = 1'b0;
   localparam logic ADDR_EN   = 1'b1;

   // mask of status positions that hold a register (plain events and errors)
   function automatic logic [63:0] impl_mask(input int lo, input int hi);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < N_PLAIN; i++) m[i] = 1'b1;
      for (int i = lo + 1; i <= hi; i++) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] fall
);

   if (N < 1) begin : g_bad_n
      $error("irq_fall_det: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[i];
      end
      assign fall[i] = prev_q & ~lvl[i];
   end

endmodule

// File: rtl/irq_fill_cross.sv
module irq_fill_cross #(
   parameter int BUF_DEPTH = 512,
   parameter int FILL_W    = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_mode,
   input  logic [FILL_W-1:0] buf_fill,
   input  logic [FILL_W-1:0] blk_len,
   output logic              rd_set,
   output logic              wr_set
);

   localparam logic [FILL_W:0] DEPTH_X = (FILL_W+1)'(BUF_DEPTH);

   if (BUF_DEPTH < 1) begin : g_bad_depth
      $error("irq_fill_cross: BUF_DEPTH must be positive");
   end
   if (FILL_W < $clog2(BUF_DEPTH + 1)) begin : g_bad_fw
      $error("irq_fill_cross: FILL_W too narrow for BUF_DEPTH");
   end

   logic [FILL_W:0] fill_x;
   logic [FILL_W:0] len_x;
   logic [FILL_W:0] free_x;
   logic [1:0]      ge;
   logic [1:0]      ge_q;
   logic [1:0]      dir_ok;

   assign fill_x = {1'b0, buf_fill};
   assign len_x  = {1'b0, blk_len};
   assign free_x = (fill_x > DEPTH_X) ? '0 : (DEPTH_X - fill_x);
   assign dir_ok = {~rd_mode, rd_mode};

   // index 0: data available for reading, index 1: space available for writing
   for (genvar d = 0; d < 2; d++) begin : g_dir
      logic [FILL_W:0] amount;
      if (d == 0) begin : g_rd
         assign amount = fill_x;
      end else begin : g_wr
         assign amount = free_x;
      end
      assign ge[d] = (len_x != '0) && (amount >= len_x);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ge_q[d] <= 1'b0;
         else        ge_q[d] <= ge[d];
      end
   end

   assign rd_set = dir_ok[0] & ge[0] & ~ge_q[0];
   assign wr_set = dir_ok[1] & ge[1] & ~ge_q[1];

endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
   parameter int STAT_W = 32,
   parameter int ERR_LO = 15,
   parameter int ERR_HI = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set_vec,
   input  logic [STAT_W-1:0] clr_vec,
   output logic [STAT_W-1:0] stat_o
);

   localparam logic [63:0] MASK64 = irq_evt_pkg::impl_mask(ERR_LO, ERR_HI);
   localparam logic [STAT_W-1:0] IMPL = MASK64[STAT_W-1:0];

   if (ERR_HI >= STAT_W || ERR_LO >= ERR_HI) begin : g_bad_field
      $error("irq_stat_bank: error field does not fit the status word");
   end

   logic [STAT_W-1:0] stat_q;

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (IMPL[i]) begin : g_reg
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q <= 1'b0;
            else if (set_vec[i]) q <= 1'b1;      // set wins over a clear
            else if (clr_vec[i]) q <= 1'b0;
         end
         assign stat_q[i] = q;
      end else begin : g_none
         assign stat_q[i] = 1'b0;
      end
   end

   always_comb begin
      stat_o         = stat_q;
      stat_o[ERR_LO] = |stat_q[ERR_HI:ERR_LO+1];
   end

endmodule

// File: rtl/irq_mask_out.sv
module irq_mask_out #(
   parameter int STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic [STAT_W-1:0] en_wdata,
   input  logic [STAT_W-1:0] stat_vec,
   output logic [STAT_W-1:0] en_vec,
   output logic              irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_vec <= '0;
      else if (en_wr) en_vec <= en_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(stat_vec & en_vec);
   end

endmodule

// File: rtl/irq_evt_unit.sv
module irq_evt_unit #(
   parameter int STAT_W    = 32,
   parameter int ERR_LO    = 15,
   parameter int ERR_HI    = 24,
   parameter int BUF_DEPTH = 512,
   parameter int N_ERR     = ERR_HI - ERR_LO,
   parameter int FILL_W    = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_busy,
   input  logic              rd_active,
   input  logic              dat_active,
   input  logic              rd_mode,
   input  logic              gap_halt,
   input  logic              dma_evt,
   input  logic              card_evt,
   input  logic              boot_evt,
   input  logic [N_ERR-1:0]  err_evt,
   input  logic [FILL_W-1:0] buf_fill,
   input  logic [FILL_W-1:0] blk_len,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [STAT_W-1:0] reg_wdata,
   output logic [STAT_W-1:0] reg_rdata,
   output logic              irq
);
   import irq_evt_pkg::*;

   if (ERR_LO < N_PLAIN) begin : g_bad_lo
      $error("irq_evt_unit: error field overlaps the plain event bits");
   end
   if (N_ERR != ERR_HI - ERR_LO) begin : g_bad_nerr
      $error("irq_evt_unit: N_ERR must equal ERR_HI - ERR_LO");
   end
   if (STAT_W > 64) begin : g_bad_w
      $error("irq_evt_unit: STAT_W above 64 not supported");
   end

   logic [2:0]        fall;
   logic              rd_set;
   logic              wr_set;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] clr_vec;
   logic [STAT_W-1:0] stat_vec;
   logic [STAT_W-1:0] en_vec;
   logic              stat_wr;
   logic              en_wr;

   irq_fall_det #(.N(3)) u_fall (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({dat_active, rd_active, cmd_busy}),
      .fall (fall)
   );

   irq_fill_cross #(.BUF_DEPTH(BUF_DEPTH), .FILL_W(FILL_W)) u_fill (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_mode (rd_mode),
      .buf_fill(buf_fill),
      .blk_len (blk_len),
      .rd_set  (rd_set),
      .wr_set  (wr_set)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[P_CMD]   = fall[0];
      set_vec[P_XFER]  = (rd_mode & fall[1]) | (~rd_mode & fall[2]) | gap_halt;
      set_vec[P_GAP]   = gap_halt;
      set_vec[P_RDRDY] = rd_set;
      set_vec[P_WRRDY] = wr_set;
      set_vec[P_DMA]   = dma_evt;
      set_vec[P_CARD]  = card_evt;
      set_vec[P_BOOT]  = boot_evt;
      for (int i = 0; i < N_ERR; i++) set_vec[ERR_LO+1+i] = err_evt[i];
   end

   assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);
   assign en_wr   = reg_wr && (reg_addr == ADDR_EN);
   assign clr_vec = stat_wr ? reg_wdata : '0;

   irq_stat_bank #(.STAT_W(STAT_W), .ERR_LO(ERR_LO), .ERR_HI(ERR_HI)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .stat_o (stat_vec)
   );

   irq_mask_out #(.STAT_W(STAT_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_wr   (en_wr),
      .en_wdata(reg_wdata),
      .stat_vec(stat_vec),
      .en_vec  (en_vec),
      .irq     (irq)
   );

   assign reg_rdata = (reg_addr == ADDR_EN) ? en_vec : stat_vec;

endmodule

// File: rtl/irq_evt_unit_chk.sv
module irq_evt_unit_chk #(
   parameter int STAT_W = 32,
   parameter int ERR_LO = 15,
   parameter int ERR_HI = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_busy,
   input logic              dma_evt,
   input logic              card_evt,
   input logic              clr_dma,
   input logic [STAT_W-1:0] stat_vec,
   input logic [STAT_W-1:0] en_vec,
   input logic              irq
);
   import irq_evt_pkg::*;

   localparam logic [63:0] MASK64 = impl_mask(ERR_LO, ERR_HI);
   localparam logic [STAT_W-1:0] UNUSED = ~MASK64[STAT_W-1:0] & ~(STAT_W'(1) << ERR_LO);

   AST_CMD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cmd_busy) && $past(rst_n)) |=> stat_vec[P_CMD]);                        // R2

   AST_SUM_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (|stat_vec[ERR_HI:ERR_LO+1]) |-> stat_vec[ERR_LO]);                           // R9

   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_dma && !dma_evt) |=> !stat_vec[P_DMA]);                                  // R10

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      card_evt |=> stat_vec[P_CARD]);                                               // R11

   AST_IRQ_REG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == (|$past(stat_vec & en_vec))));                               // R12

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vec & UNUSED) == '0);                                                   // R13

endmodule

bind irq_evt_unit irq_evt_unit_chk #(.STAT_W(STAT_W), .ERR_LO(ERR_LO), .ERR_HI(ERR_HI)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cmd_busy(cmd_busy),
   .dma_evt (dma_evt),
   .card_evt(card_evt),
   .clr_dma (reg_wr && (reg_addr == 1'b0) && reg_wdata[irq_evt_pkg::P_DMA]),
   .stat_vec(stat_vec),
   .en_vec  (en_vec),
   .irq     (irq)
);

// File: tb/sim_irq_evt_unit.sv
`timescale 1ns/1ps
module sim_irq_evt_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_busy = 0, rd_active = 0, dat_active = 0, rd_mode = 0;
   logic        gap_halt = 0, dma_evt = 0, card_evt = 0, boot_evt = 0;
   logic [8:0]  err_evt = '0;
   logic [9:0]  buf_fill = '0, blk_len = '0;
   logic        reg_wr = 0, reg_addr = 0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_evt_unit u0 (
      .clk(clk), .rst_n(rst_n), .cmd_busy(cmd_busy), .rd_active(rd_active),
      .dat_active(dat_active), .rd_mode(rd_mode), .gap_halt(gap_halt),
      .dma_evt(dma_evt), .card_evt(card_evt), .boot_evt(boot_evt),
      .err_evt(err_evt), .buf_fill(buf_fill), .blk_len(blk_len),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(0, d); chk("R1 status", d, 0);
      rd(1, d); chk("R1 enable", d, 0);
      chk("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_cmd();
      logic [31:0] d;
      cmd_busy = 1; step(); step();
      rd(0, d); chk("R2 rise/level", d, 0);
      cmd_busy = 0; step();
      rd(0, d); chk("R2 fall", d, 32'h1);
      wr(0, 32'h0);
      rd(0, d); chk("R10 write 0 keeps", d, 32'h1);
      wr(0, 32'h1);
      rd(0, d); chk("R10 write 1 clears", d, 0);
   endtask

   task automatic t_read_mode();
      logic [31:0] d;
      rd_mode = 1; dat_active = 1; step();
      dat_active = 0; step();
      rd(0, d); chk("R3 dat fall ignored", d, 0);
      rd_active = 1; step();
      rd_active = 0; step();
      rd(0, d); chk("R3 rd fall", d, 32'h2);
      wr(0, 32'h2);
   endtask

   task automatic t_write_mode();
      logic [31:0] d;
      rd_mode = 0; rd_active = 1; step();
      rd_active = 0; step();
      rd(0, d); chk("R4 rd fall ignored", d, 0);
      dat_active = 1; step();
      dat_active = 0; step();
      rd(0, d); chk("R4 dat fall", d, 32'h2);
      wr(0, 32'h2);
   endtask

   task automatic t_gap();
      logic [31:0] d;
      gap_halt = 1; step(); gap_halt = 0;
      rd(0, d); chk("R5 gap", d, 32'h6);
      wr(0, 32'h6);
      rd(0, d); chk("R5 cleared", d, 0);
   endtask

   task automatic t_rd_thresh();
      logic [31:0] d;
      rd_mode = 1; blk_len = 8; buf_fill = 4; step();
      rd(0, d); chk("R6 below", d, 0);
      buf_fill = 8; step();
      rd(0, d); chk("R6 cross", d, 32'h8);
      wr(0, 32'h8);
      buf_fill = 9; step();
      rd(0, d); chk("R6 once per crossing", d, 0);
      buf_fill = 0; step();
   endtask

   task automatic t_wr_thresh();
      logic [31:0] d;
      rd_mode = 0; buf_fill = 508; step();
      rd(0, d); chk("R7 free below", d, 0);
      buf_fill = 500; step();
      rd(0, d); chk("R7 free cross", d, 32'h10);
      buf_fill = 0; wr(0, 32'h10);
      rd(0, d); chk("R7 no repeat", d, 0);
   endtask

   task automatic t_pulses();
      logic [31:0] d;
      dma_evt = 1; card_evt = 1; boot_evt = 1; err_evt = 9'h101; step();
      dma_evt = 0; card_evt = 0; boot_evt = 0; err_evt = '0;
      rd(0, d); chk("R8 pulses", d, 32'h0101_80E0);
      wr(0, 32'h0000_8000);
      rd(0, d); chk("R9 summary not writable", d, 32'h0101_80E0);
      wr(0, 32'h0001_0000);
      rd(0, d); chk("R9 summary held by bit24", d, 32'h0100_80E0);
      wr(0, 32'h0100_0000);
      rd(0, d); chk("R9 summary clears", d, 32'h0000_00E0);
      wr(0, 32'h0000_00E0);
   endtask

   task automatic t_set_wins();
      logic [31:0] d;
      dma_evt = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h20; step();
      dma_evt = 0; reg_wr = 0; reg_wdata = '0;
      rd(0, d); chk("R11 set wins", d, 32'h20);
      wr(0, 32'h20);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(1, 32'h40);
      card_evt = 1; step(); card_evt = 0;
      chk("R12 latency", {31'b0, irq}, 0);
      step(); chk("R12 enabled set", {31'b0, irq}, 1);
      wr(0, 32'h40);
      chk("R12 registered after clear", {31'b0, irq}, 1);
      step(); chk("R12 drops", {31'b0, irq}, 0);
      wr(1, 32'h8000);
      err_evt = 9'h008; step(); err_evt = '0;
      step(); chk("R12 via summary", {31'b0, irq}, 1);
      rd(0, d); chk("R8 err3", d, 32'h0008_8000);
      wr(0, 32'h0008_0000); step();
      chk("R12 summary cleared", {31'b0, irq}, 0);
      wr(1, 32'h1);
      dma_evt = 1; step(); dma_evt = 0; step();
      chk("R12 masked", {31'b0, irq}, 0);
      wr(0, 32'h20); wr(1, 0);
   endtask

   task automatic t_unused();
      logic [31:0] d;
      gap_halt = 1; dma_evt = 1; card_evt = 1; boot_evt = 1; err_evt = '1; step();
      gap_halt = 0; dma_evt = 0; card_evt = 0; boot_evt = 0; err_evt = '0;
      rd(0, d); chk("R13 unused zero", d, 32'h01FF_80E6);
      wr(1, 32'hFFFF_FFFF);
      rd(1, d); chk("R13 enable readback", d, 32'hFFFF_FFFF);
      wr(0, 32'hFFFF_FFFF);
      rd(0, d); chk("R10 clear all", d, 0);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_cmd();
      t_read_mode();
      t_write_mode();
      t_gap();
      t_rd_thresh();
      t_wr_thresh();
      t_pulses();
      t_set_wins();
      t_irq();
      t_unused();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule